// File: doc/BRIEF.md
# Multiplexed-Bus Byte Memory Access Controller

This block gives a host access to a 4096-byte memory across a shared 8-bit address/data bus. The host builds a 12-bit address in two parts. A rising edge on the low strobe captures the bus byte as address bits 7:0. A rising edge on the high strobe captures bus bits 3:0 as address bits 11:8. Each part stays latched until its own strobe rises again, so a run of accesses within one 256-byte page needs only low-strobe updates.

A store takes place when the active-low write enable is released. The byte on the bus in that cycle goes to the latched address. Stores are blocked while the power-good input is low. A read drives the addressed byte out while the active-low output enable is held. The bus is modelled as a data-out value plus a drive flag. The memory has no select line of its own: it is engaged only through the two enables. Asserting both enables together breaks the protocol. The block then releases the bus, discards the overlapping write pulse and raises a sticky error flag.

Top module: `mbus_sram_ctrl`

## Requirements
- R1: When the low strobe is sampled high after being sampled low, the bus byte sampled in that cycle becomes address bits 7:0 from the next cycle on.
- R2: When the high strobe is sampled high after being sampled low, bus bits 3:0 sampled in that cycle become address bits 11:8. Bus bits 7:4 have no effect on the address.
- R3: Each address half keeps its value until its own strobe rises again. Holding a strobe high does not reload it.
- R4: When write enable is sampled low and then high, the bus byte sampled in the high cycle is stored at the latched address. This applies only if power-good is high in that cycle and no conflict occurred during the pulse.
- R5: While output enable is low and write enable is high, bus_oe_o is 1 and bus_o shows the byte at the latched address in the same cycle.
- R6: With both enables high, bus_oe_o is 0 and memory contents do not change.
- R7: A write-enable release that happens while power-good is low stores nothing.
- R8: While both enables are low, bus_oe_o is 0. proto_err_o goes to 1 on the next cycle and stays at 1 until reset. The write pulse that overlapped the conflict stores nothing.
- R9: Reset clears both address halves to 0, proto_err_o to 0 and bus_oe_o to 0. Memory contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 8 | Bus value driven by the host |
| as_lo_i | input | 1 | Strobe for address bits 7:0 |
| as_hi_i | input | 1 | Strobe for address bits 11:8 |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| pwr_ok_i | input | 1 | Power-good; stores are allowed only when high |
| bus_o | output | 8 | Byte read from memory |
| bus_oe_o | output | 1 | Block drives the bus |
| proto_err_o | output | 1 | Sticky error: both enables were seen low together |

## Verification
Every address is written once and then read back. The high half is strobed only once per page, so a design that lost a latched half between accesses, or that needed both strobes every time, would return wrong bytes. The high strobe is loaded with nonzero upper bus bits. A design that used those bits would fall outside the 12-bit space or alias to another page. The remaining cases are a strobe held high while the bus changes, a write released with power-good low, and an overlapping enable pulse. A design that mishandled any of these would reload the address, corrupt a stored byte, or drive the bus during the conflict. A reset after the sweep confirms that the address returns to 0 while the memory keeps its contents.

// File: rtl/mbus_sram_pkg.sv
package mbus_sram_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LO_W   = 8;
  localparam int unsigned HI_W   = 4;
  localparam int unsigned ADDR_W = LO_W + HI_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
endpackage

// File: rtl/mbus_addr_half.sv
// One strobe-loaded address half; loads on a sampled rising edge only.
module mbus_addr_half #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      q_o   <= '0;
    end else begin
      stb_q <= stb_i;
      if (stb_i && !stb_q) q_o <= d_i;
    end
  end
endmodule

// File: rtl/mbus_wr_ctrl.sv
// Enable decode: store on write-enable release, conflict tracking.
module mbus_wr_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_ni,
  input  logic oe_ni,
  input  logic pwr_ok_i,
  output logic wr_fire_o,
  output logic drive_o,
  output logic err_o
);
  logic we_n_q;
  logic clash_q;
  logic both_low;

  assign both_low = !we_ni && !oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_n_q  <= 1'b1;
      clash_q <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      we_n_q <= we_ni;
      if (both_low)   clash_q <= 1'b1;
      else if (we_ni) clash_q <= 1'b0;
      if (both_low)   err_o   <= 1'b1;
    end
  end

  // clash_q covers any conflict seen earlier in the same write pulse
  assign wr_fire_o = !we_n_q && we_ni && !clash_q && pwr_ok_i;
  assign drive_o   = !oe_ni && we_ni;
endmodule

// File: rtl/mbus_mem.sv
module mbus_mem #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wd_i,
  output logic [DW-1:0] rd_o
);
  localparam int unsigned N = 1 << AW;
  logic [DW-1:0] mem_q [N];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wd_i;
  end

  assign rd_o = mem_q[addr_i];
endmodule

// File: rtl/mbus_sram_ctrl.sv
module mbus_sram_ctrl
  import mbus_sram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              as_lo_i,
  input  logic              as_hi_i,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              pwr_ok_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              proto_err_o
);
  logic [LO_W-1:0]   addr_lo;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_en;
  logic              drive;

  mbus_addr_half #(.W(LO_W)) u_lo (
    .clk_i, .rst_ni, .stb_i(as_lo_i), .d_i(bus_i[LO_W-1:0]), .q_o(addr_lo)
  );

  // upper bus bits deliberately unused for the high half
  mbus_addr_half #(.W(HI_W)) u_hi (
    .clk_i, .rst_ni, .stb_i(as_hi_i), .d_i(bus_i[HI_W-1:0]), .q_o(addr_hi)
  );

  assign addr_q = {addr_hi, addr_lo};

  mbus_wr_ctrl u_wr (
    .clk_i, .rst_ni, .we_ni, .oe_ni, .pwr_ok_i,
    .wr_fire_o(wr_en), .drive_o(drive), .err_o(proto_err_o)
  );

  mbus_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk_i, .we_i(wr_en), .addr_i(addr_q), .wd_i(bus_i), .rd_o(bus_o)
  );

  assign bus_oe_o = drive;
endmodule

// File: rtl/mbus_sram_ctrl_chk.sv
module mbus_sram_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  bus_i,
  input logic        as_lo_i,
  input logic        as_hi_i,
  input logic        we_ni,
  input logic        oe_ni,
  input logic        pwr_ok_i,
  input logic        bus_oe_o,
  input logic        proto_err_o,
  input logic [11:0] addr_q,
  input logic        wr_en
);
  logic seen_lo_q, seen_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_lo_q <= 1'b0;
      seen_hi_q <= 1'b0;
    end else begin
      seen_lo_q <= as_lo_i;
      seen_hi_q <= as_hi_i;
    end
  end

  p_lo_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_lo_i && !seen_lo_q) |=> addr_q[7:0] == $past(bus_i));
  p_hi_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_hi_i && !seen_hi_q) |=> addr_q[11:8] == $past(bus_i[3:0]));
  p_hi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(as_hi_i && !seen_hi_q) |=> $stable(addr_q[11:8]));
  p_lo_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(as_lo_i && !seen_lo_q) |=> $stable(addr_q[7:0]));
  p_wr_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (we_ni && $past(!we_ni) && oe_ni));
  p_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && we_ni) |-> bus_oe_o);
  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni && we_ni) |-> !bus_oe_o);
  p_no_power_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |-> !wr_en);
  p_clash_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && !we_ni) |-> !bus_oe_o);
  p_clash_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && !we_ni) |=> proto_err_o);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
endmodule

bind mbus_sram_ctrl mbus_sram_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_i(bus_i), .as_lo_i(as_lo_i),
  .as_hi_i(as_hi_i), .we_ni(we_ni), .oe_ni(oe_ni), .pwr_ok_i(pwr_ok_i),
  .bus_oe_o(bus_oe_o), .proto_err_o(proto_err_o), .addr_q(addr_q),
  .wr_en(wr_en)
);

// File: tb/mbus_sram_ctrl_tb.sv
`timescale 1ns/1ps
module mbus_sram_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] bus_i = 8'h00;
  logic       as_lo_i = 1'b0, as_hi_i = 1'b0;
  logic       we_ni = 1'b1, oe_ni = 1'b1, pwr_ok_i = 1'b1;
  logic [7:0] bus_o;
  logic       bus_oe_o, proto_err_o;

  int total = 0, bad = 0;
  logic [7:0] exp_mem [4096];

  always #4 clk_i = ~clk_i;

  mbus_sram_ctrl u_dut (.*);

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7) ^ (a >> 8) ^ 8'h5A);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_lo(logic [7:0] v);
    @(negedge clk_i); bus_i = v; as_lo_i = 1'b1;
    @(negedge clk_i); as_lo_i = 1'b0;
  endtask

  task automatic set_hi(logic [7:0] v);
    @(negedge clk_i); bus_i = v; as_hi_i = 1'b1;
    @(negedge clk_i); as_hi_i = 1'b0;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk_i); bus_i = d; we_ni = 1'b0;
    @(negedge clk_i); we_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic rd(output logic [7:0] d, output logic oe);
    @(negedge clk_i); oe_ni = 1'b0; bus_i = 8'hEE;
    #1; d = bus_o; oe = bus_oe_o;
    @(negedge clk_i); oe_ni = 1'b1;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk_i);
    chk("R9 oe", 32'(bus_oe_o), 0);
    chk("R9 err", 32'(proto_err_o), 0);
    rst_ni = 1'b1;

    // R4 R1 R3: full write sweep, high half strobed once per page
    for (int h = 0; h < 16; h++) begin
      set_hi(8'(h));
      for (int l = 0; l < 256; l++) begin
        set_lo(8'(l));
        wr(pat(h * 256 + l));
        exp_mem[h * 256 + l] = pat(h * 256 + l);
      end
    end
    // R5 R2: read sweep with junk in bus bits 7:4 on the high strobe
    for (int h = 0; h < 16; h++) begin
      set_hi(8'(8'hA0 | h));
      for (int l = 0; l < 256; l++) begin
        set_lo(8'(l));
        rd(d, oe);
        chk("R5 drive", 32'(oe), 1);
        chk("R2 R5 data", 32'(d), 32'(exp_mem[h * 256 + l]));
      end
    end
    // R6: idle
    #1; chk("R6 idle", 32'(bus_oe_o), 0);
    chk("R8 no err yet", 32'(proto_err_o), 0);

    // R3: held strobe does not reload
    set_hi(8'h02); set_lo(8'h10);
    @(negedge clk_i); bus_i = 8'h33; as_lo_i = 1'b1;
    @(negedge clk_i); bus_i = 8'h77;
    @(negedge clk_i); as_lo_i = 1'b0;
    rd(d, oe);
    chk("R3 held strobe", 32'(d), 32'(exp_mem[12'h233]));

    // R7: no store without power-good
    set_lo(8'h05); set_hi(8'h01);
    pwr_ok_i = 1'b0;
    wr(~exp_mem[12'h105]);
    pwr_ok_i = 1'b1;
    rd(d, oe);
    chk("R7 blocked", 32'(d), 32'(exp_mem[12'h105]));

    // R8: overlapping enables
    set_lo(8'h06);
    @(negedge clk_i); bus_i = ~exp_mem[12'h106]; we_ni = 1'b0; oe_ni = 1'b0;
    #1; chk("R8 released", 32'(bus_oe_o), 0);
    @(negedge clk_i); oe_ni = 1'b1;
    chk("R8 err set", 32'(proto_err_o), 1);
    @(negedge clk_i); we_ni = 1'b1;
    @(negedge clk_i);
    rd(d, oe);
    chk("R8 write discarded", 32'(d), 32'(exp_mem[12'h106]));
    chk("R8 sticky", 32'(proto_err_o), 1);

    // R4: a clean write after the conflict still works
    wr(8'hC3); exp_mem[12'h106] = 8'hC3;
    rd(d, oe);
    chk("R4 post-conflict write", 32'(d), 32'hC3);

    // R9: reset clears address and flag, keeps memory
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R9 err cleared", 32'(proto_err_o), 0);
    rd(d, oe);
    chk("R9 addr zero", 32'(d), 32'(exp_mem[0]));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule